// File: doc/BRIEF.md
# Token-Ring Controller Configuration and Timeout Unit

This block keeps the byte-wide configuration register of a token-passing network controller and turns its fields into control signals for the rest of the controller. A host write replaces the whole register, and the register always reads back as it was last written. One bit drives a level-held software reset for the status, next-ID and diagnostic-status registers elsewhere in the controller. One bit gates the three line-driver enables. One bit selects backplane signalling, in which only the transmit-enable driver is used. A two-bit extended-timeout field selects the limits of three timeout counters: response, idle and reconfiguration.

The protocol engine raises driver requests and start or restart strobes. The unit returns the gated driver enables and a one-cycle expired flag per counter. Limits are held as clock-cycle counts for a 20 MHz clock. Two divisor parameters scale them down: one for the microsecond-range counters and one for the reconfiguration counter.

Top module: `ring_cfg_timer`

## Requirements
- R1: Synchronous reset clears the configuration register to 0x00. A write stores the full byte at the next clock edge. Without a write the register holds its value, and `cfg_rdata` always shows it.
- R2: `soft_rst` equals register bit 7 and stays high until a later write clears that bit. Setting it leaves the configuration register as written.
- R3: `chain_en` equals register bit 6, and `bp_mode` equals register bit 2.
- R4: While register bit 5 (transmit enable) is 0, all three driver outputs are 0 one cycle later, whatever the requests.
- R5: While register bit 2 (backplane) is 1, the two pulse driver outputs are 0 one cycle later. The transmit driver output still follows its request when bit 5 is 1.
- R6: With bit 5 = 1 and bit 2 = 0, each driver output equals its request one cycle later.
- R7: The timeout code is {bit 4, bit 3}. Codes 00/01/10/11 give response limits of 5968/2984/1494/374 cycles and idle limits of 6560/3280/1640/410 cycles, each divided by SHORT_DIV (at least 1).
- R8: Reconfiguration limits are 8,400,000 cycles for codes 00, 01 and 10, and 4,200,000 for code 11, each divided by LONG_DIV (at least 1).
- R9: A start strobe sampled at edge E makes that counter's expired flag high for exactly one cycle, after edge E plus the limit. The counter is then idle.
- R10: A start strobe while the counter runs is ignored. A restart strobe restarts the count from that edge, whether the counter is running or idle.
- R11: While `soft_rst` is high, every counter is cleared, strobes are ignored and no expired flag rises. A count in progress at that time never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register contents |
| soft_rst | output | 1 | Level-held reset to status, next-ID and diagnostic registers |
| chain_en | output | 1 | Command-chaining enable |
| bp_mode | output | 1 | Backplane signalling select |
| drv_a_req | input | 1 | First pulse driver request |
| drv_b_req | input | 1 | Second pulse driver request |
| drv_tx_req | input | 1 | Transmit driver request |
| drv_a_o | output | 1 | Gated first pulse driver enable |
| drv_b_o | output | 1 | Gated second pulse driver enable |
| drv_tx_o | output | 1 | Gated transmit driver enable |
| tmo_start | input | 3 | Start strobes: [0] response, [1] idle, [2] reconfiguration |
| tmo_restart | input | 3 | Restart strobes, same order |
| tmo_expired | output | 3 | One-cycle expired flags, same order |

## Verification
The hardest case to reach is an interaction inside a running count. Examples are a second start that must be ignored, a restart that moves the expiry, and a software reset that must cancel a count already in progress. From the ports, these can only be reached by timing strobes and register writes against a counter that the bench tracks itself. The bench counts edges from each start. It places the extra start, the restart and the reset write at chosen edge offsets, then measures the edge on which the flag rises. Every timeout code is swept for all three counters with reduced divisors, and the expiry edge is compared with a limit computed from the microsecond values.

// File: rtl/ring_cfg_pkg.sv
package ring_cfg_pkg;

  localparam int unsigned CFG_W     = 8;
  localparam int unsigned BIT_SRST  = 7;
  localparam int unsigned BIT_CHAIN = 6;
  localparam int unsigned BIT_TXEN  = 5;
  localparam int unsigned BIT_ETHI  = 4;
  localparam int unsigned BIT_ETLO  = 3;
  localparam int unsigned BIT_BP    = 2;
  localparam int unsigned N_TMO     = 3;

  typedef enum logic [1:0] {
    TMO_RESP = 2'd0,
    TMO_IDLE = 2'd1,
    TMO_RCFG = 2'd2
  } tmo_id_e;

  // Cycle counts at a 20 MHz reference clock.
  function automatic int unsigned resp_base(input logic [1:0] code);
    case (code)
      2'b00:   return 32'd5968;
      2'b01:   return 32'd2984;
      2'b10:   return 32'd1494;
      default: return 32'd374;
    endcase
  endfunction

  function automatic int unsigned idle_base(input logic [1:0] code);
    case (code)
      2'b00:   return 32'd6560;
      2'b01:   return 32'd3280;
      2'b10:   return 32'd1640;
      default: return 32'd410;
    endcase
  endfunction

  function automatic int unsigned rcfg_base(input logic [1:0] code);
    return (code == 2'b11) ? 32'd4200000 : 32'd8400000;
  endfunction

  function automatic int unsigned scale_lim(input int unsigned base,
                                            input int unsigned div);
    int unsigned q;
    q = base / ((div == 0) ? 1 : div);
    return (q == 0) ? 32'd1 : q;
  endfunction

endpackage

// File: rtl/ring_cfg_reg.sv
module ring_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end

  p_hold_value_r1: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));

  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q == $past(wdata)));

endmodule

// File: rtl/ring_drive_gate.sv
module ring_drive_gate (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic backplane,
  input  logic a_req,
  input  logic b_req,
  input  logic tx_req,
  output logic a_o,
  output logic b_o,
  output logic tx_o
);

  logic pulse_ok;
  assign pulse_ok = tx_en && !backplane;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o  <= 1'b0;
      b_o  <= 1'b0;
      tx_o <= 1'b0;
    end else begin
      a_o  <= pulse_ok && a_req;
      b_o  <= pulse_ok && b_req;
      tx_o <= tx_en && tx_req;
    end
  end

  p_tx_off_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !(a_o || b_o || tx_o));

  p_bp_no_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    backplane |=> !(a_o || b_o));

endmodule

// File: rtl/ring_tmo_counter.sv
module ring_tmo_counter #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          start,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      run     <= 1'b0;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (restart || (start && !run)) begin
        run <= 1'b1;
        cnt <= {{(CW-1){1'b0}}, 1'b1};
      end else if (run) begin
        if (cnt >= limit) begin
          expired <= 1'b1;
          run     <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);

  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    hold |=> !expired);

endmodule

// File: rtl/ring_cfg_timer.sv
module ring_cfg_timer
  import ring_cfg_pkg::*;
#(
  parameter int unsigned SHORT_DIV = 1,
  parameter int unsigned LONG_DIV  = 1,
  parameter int unsigned CNT_W     = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [CFG_W-1:0]       cfg_rdata,
  output logic                   soft_rst,
  output logic                   chain_en,
  output logic                   bp_mode,
  input  logic                   drv_a_req,
  input  logic                   drv_b_req,
  input  logic                   drv_tx_req,
  output logic                   drv_a_o,
  output logic                   drv_b_o,
  output logic                   drv_tx_o,
  input  logic [N_TMO-1:0]       tmo_start,
  input  logic [N_TMO-1:0]       tmo_restart,
  output logic [N_TMO-1:0]       tmo_expired
);

  logic [CFG_W-1:0] cfg;
  logic [1:0]       et_code;
  logic [CNT_W-1:0] lim [N_TMO];

  ring_cfg_reg #(.W(CFG_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .q     (cfg)
  );

  assign cfg_rdata = cfg;
  assign soft_rst  = cfg[BIT_SRST];
  assign chain_en  = cfg[BIT_CHAIN];
  assign bp_mode   = cfg[BIT_BP];
  assign et_code   = {cfg[BIT_ETHI], cfg[BIT_ETLO]};

  ring_drive_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (cfg[BIT_TXEN]),
    .backplane (cfg[BIT_BP]),
    .a_req     (drv_a_req),
    .b_req     (drv_b_req),
    .tx_req    (drv_tx_req),
    .a_o       (drv_a_o),
    .b_o       (drv_b_o),
    .tx_o      (drv_tx_o)
  );

  always_comb begin
    lim[TMO_RESP] = CNT_W'(scale_lim(resp_base(et_code), SHORT_DIV));
    lim[TMO_IDLE] = CNT_W'(scale_lim(idle_base(et_code), SHORT_DIV));
    lim[TMO_RCFG] = CNT_W'(scale_lim(rcfg_base(et_code), LONG_DIV));
  end

  for (genvar g = 0; g < N_TMO; g++) begin : g_tmo
    ring_tmo_counter #(.CW(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .hold    (cfg[BIT_SRST]),
      .start   (tmo_start[g]),
      .restart (tmo_restart[g]),
      .limit   (lim[g]),
      .expired (tmo_expired[g])
    );
  end

  p_no_expiry_in_reset_r11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (tmo_expired == '0));

endmodule

// File: tb/ring_cfg_timer_bench.sv
module ring_cfg_timer_bench;

  localparam int unsigned SDIV = 2;
  localparam int unsigned LDIV = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       soft_rst, chain_en, bp_mode;
  logic       drv_a_req = 1'b0, drv_b_req = 1'b0, drv_tx_req = 1'b0;
  logic       drv_a_o, drv_b_o, drv_tx_o;
  logic [2:0] tmo_start = '0, tmo_restart = '0;
  logic [2:0] tmo_expired;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ring_cfg_timer #(.SHORT_DIV(SDIV), .LONG_DIV(LDIV)) u_ring_cfg_timer (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .soft_rst(soft_rst), .chain_en(chain_en),
    .bp_mode(bp_mode), .drv_a_req(drv_a_req), .drv_b_req(drv_b_req),
    .drv_tx_req(drv_tx_req), .drv_a_o(drv_a_o), .drv_b_o(drv_b_o),
    .drv_tx_o(drv_tx_o), .tmo_start(tmo_start), .tmo_restart(tmo_restart),
    .tmo_expired(tmo_expired)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Expected limits from microsecond figures at 20 cycles per microsecond.
  function automatic int exp_lim(input int idx, input int code);
    int tenths;
    int q;
    if (idx == 2) begin
      q = ((code == 3) ? 210 : 420) * 20000 / LDIV;
    end else begin
      if (idx == 0) tenths = (code == 0) ? 2984 : (code == 1) ? 1492 : (code == 2) ? 747 : 187;
      else          tenths = (code == 0) ? 3280 : (code == 1) ? 1640 : (code == 2) ? 820 : 205;
      q = tenths * 2 / int'(SDIV);
    end
    return (q < 1) ? 1 : q;
  endfunction

  // Start at edge E0 and record the edge offset of the first expiry.
  // Optional extra start at edge xs and restart at edge rs (0 = none).
  task automatic run_tmo(input int idx, input int xs, input int rs,
                         input int span, output int first, output int tail);
    first = -1;
    tail = 0;
    @(negedge clk);
    tmo_start[idx] = 1'b1;
    @(negedge clk);
    tmo_start[idx] = 1'b0;
    for (int k = 1; k <= span; k++) begin
      @(negedge clk);
      tmo_start[idx] = 1'b0;
      tmo_restart[idx] = 1'b0;
      if (tmo_expired[idx] && first < 0) first = k;
      if (first > 0 && k == first + 1) tail = int'(tmo_expired[idx]);
      if (xs > 0 && k == xs - 1) tmo_start[idx] = 1'b1;
      if (rs > 0 && k == rs - 1) tmo_restart[idx] = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first, tail, lim, seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset cfg", cfg_rdata, 0);
    chk("R4 reset drivers", {drv_a_o, drv_b_o, drv_tx_o}, 0);
    chk("R9 reset expired", tmo_expired, 0);

    // R1 R2 R3: every byte value written and read back.
    for (int v = 0; v < 256; v++) begin
      wr_cfg(8'(v));
      chk("R1 readback", cfg_rdata, v);
      chk("R2 soft_rst", soft_rst, (v >> 7) & 1);
      chk("R3 chain/bp", {chain_en, bp_mode}, ((v >> 5) & 2) | ((v >> 2) & 1));
    end
    repeat (3) @(negedge clk);
    chk("R1 hold no write", cfg_rdata, 255);

    // R4 R5 R6: gating sweep over tx enable, backplane and requests.
    for (int m = 0; m < 4; m++) begin
      wr_cfg({2'b00, m[1], 2'b00, m[0], 2'b00});
      for (int r = 0; r < 8; r++) begin
        int tx, bp, ea, eb, et;
        tx = m[1]; bp = m[0];
        drv_a_req = r[2]; drv_b_req = r[1]; drv_tx_req = r[0];
        @(negedge clk);
        ea = tx & ~bp & r[2];
        eb = tx & ~bp & r[1];
        et = tx & r[0];
        if (tx == 0)      chk("R4 gated off", {drv_a_o, drv_b_o, drv_tx_o}, 0);
        else if (bp == 1) chk("R5 backplane", {drv_a_o, drv_b_o, drv_tx_o}, {ea[0], eb[0], et[0]});
        else              chk("R6 follow", {drv_a_o, drv_b_o, drv_tx_o}, {ea[0], eb[0], et[0]});
      end
    end
    drv_a_req = 0; drv_b_req = 0; drv_tx_req = 0;

    // R7 R8 R9: every code for every counter.
    for (int c = 0; c < 4; c++) begin
      wr_cfg({3'b001, c[1], c[0], 3'b000});
      for (int t = 0; t < 3; t++) begin
        lim = exp_lim(t, c);
        run_tmo(t, 0, 0, lim + 2, first, tail);
        chk((t == 2) ? "R8 reconfig limit" : "R7 limit", first, lim);
        chk("R9 one-cycle flag", tail, 0);
      end
    end

    // R10: extra start at edge 10 ignored, restart at edge 20 moves expiry.
    wr_cfg(8'b0011_1000);
    lim = exp_lim(0, 3);
    run_tmo(0, 10, 20, 20 + lim + 2, first, tail);
    chk("R10 restart expiry", first, 20 + lim);
    lim = exp_lim(1, 3);
    run_tmo(1, 10, 0, lim + 2, first, tail);
    chk("R10 start ignored", first, lim);

    // R11: soft reset cancels a running idle count.
    wr_cfg(8'b0010_0000);
    lim = exp_lim(1, 0);
    @(negedge clk);
    tmo_start[1] = 1'b1;
    @(negedge clk);
    tmo_start[1] = 1'b0;
    repeat (50) @(negedge clk);
    wr_cfg(8'b1010_0000);
    chk("R2 soft_rst held", soft_rst, 1);
    chk("R2 cfg kept", cfg_rdata, 8'hA0);
    tmo_start = 3'b111;
    @(negedge clk);
    tmo_start = 3'b000;
    repeat (8) @(negedge clk);
    chk("R2 soft_rst still held", soft_rst, 1);
    wr_cfg(8'b0010_0000);
    chk("R2 soft_rst released", soft_rst, 0);
    seen = 0;
    for (int k = 0; k < lim + 100; k++) begin
      @(negedge clk);
      if (tmo_expired != 0) seen = 1;
    end
    chk("R11 no expiry after soft reset", seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule